// File: doc/BRIEF.md
# Flash Program Staging Buffer

This block collects the bytes for one flash program operation before the programming engine commits them. Software first sets the fill index, usually to zero. It then writes data words into the data register. The enabled bytes of each write are packed into the buffer at the current index, and the index moves forward by the number of bytes taken.

The block also keeps the erase/program address. When the engine reports that a program operation has finished, the address advances by the number of bytes staged. Software can therefore load the address once and then repeat fill-and-program rounds. A fill must stay inside the 32-byte-aligned window that holds the starting address. A write that would run past that window is refused and raises a sticky overflow flag.

The engine reads staged bytes by position. Positions that have not been written since the last index write read as 0xFF, so those flash cells keep their erased value.

Top module: `flash_stage_buf`

## Requirements
- R1: After reset the index is 0, the address is 0, overflow is 0 and every buffer position reads 0xFF on the engine port.
- R2: A write to offset 0x28 loads the index from wdata[5:0], saturating at 32. It also marks every position unwritten and clears overflow. The byte enables are ignored for this write.
- R3: A write to offset 0x24 stores each enabled lane (lane k is wdata[8k+7:8k]) at consecutive buffer positions, in ascending lane order, starting at the index. The index then grows by the number of enabled lanes.
- R4: A data write with no lane enabled changes no byte, leaves the index unchanged and leaves overflow unchanged.
- R5: The room in the window is 32 minus the address bits [4:0]. A data write for which index plus enabled-lane count exceeds the room is dropped whole: no byte is stored and the index is unchanged. It also sets overflow.
- R6: Overflow stays set until the next index write.
- R7: A write to offset 0x20 loads the full 32-bit address. The byte enables are ignored for this write.
- R8: A one-cycle pulse on prog_done adds the index to the address. The index and the staged bytes are left unchanged. If an address write arrives in the same cycle, the pulse takes precedence and the address write is lost.
- R9: eng_byte shows the byte stored at position eng_pos, or 0xFF if that position has not been written since the last index write.
- R10: bus_rdata is combinational from bus_ofs. Offset 0x20 returns the address, offset 0x28 returns the index zero-extended, and any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_ofs | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Lane enables for data writes |
| bus_rdata | output | 32 | Register read data |
| prog_done | input | 1 | Program operation finished (one cycle) |
| eng_pos | input | 5 | Engine read position |
| eng_byte | output | 8 | Staged byte at eng_pos, or 0xFF |
| fill_level | output | 6 | Current index |
| prog_addr | output | 32 | Current erase/program address |
| overflow | output | 1 | Sticky window overflow flag |

## Verification
The hardest case to reach is the window edge. Refusal depends on the address's low bits, the current index and the lane count all at once, and that boundary moves with every start address. The stimulus sweeps all 32 start offsets in the window. For each offset it fills with whole words until one is refused, tops up with single bytes until the exact edge is reached, and then tries one more byte. The refusal is then checked both byte by byte on the engine port and through the address advance when the program operation completes.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam logic [7:0] OFS_ADDR  = 8'h20;
  localparam logic [7:0] OFS_DATA  = 8'h24;
  localparam logic [7:0] OFS_INDEX = 8'h28;

  // number of set enables in a lane mask of up to eight lanes
  function automatic logic [3:0] lane_count(input logic [7:0] be);
    logic [3:0] n;
    n = '0;
    for (int k = 0; k < 8; k++) n = n + {3'b000, be[k]};
    return n;
  endfunction
endpackage

// File: rtl/fsb_index_ctrl.sv
module fsb_index_ctrl #(
  parameter int BUF_BYTES = 32,
  parameter int BUS_BYTES = 4,
  localparam int IDX_W = $clog2(BUF_BYTES) + 1,
  localparam int POS_W = $clog2(BUF_BYTES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_wr,
  input  logic [IDX_W-1:0]     idx_raw,
  input  logic                 dat_wr,
  input  logic [BUS_BYTES-1:0] be,
  input  logic [POS_W-1:0]     addr_lo,
  output logic [IDX_W-1:0]     idx,
  output logic                 ovf,
  output logic                 accept_evt,
  output logic                 drop_evt
);
  import fsb_pkg::*;

  logic [IDX_W-1:0] room, cnt, idx_sat;
  logic [IDX_W:0]   sum;
  logic             active;

  always_comb begin
    room    = IDX_W'(BUF_BYTES) - {1'b0, addr_lo};
    cnt     = IDX_W'(lane_count(8'(be)));
    sum     = {1'b0, idx} + {1'b0, cnt};
    idx_sat = (idx_raw > IDX_W'(BUF_BYTES)) ? IDX_W'(BUF_BYTES) : idx_raw;
    active  = dat_wr && (cnt != '0);
  end

  assign accept_evt = active && (sum <= {1'b0, room});
  assign drop_evt   = active && (sum >  {1'b0, room});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      ovf <= 1'b0;
    end else if (idx_wr) begin
      idx <= idx_sat;
      ovf <= 1'b0;
    end else if (accept_evt) begin
      idx <= sum[IDX_W-1:0];
    end else if (drop_evt) begin
      ovf <= 1'b1;
    end
  end

  // R5
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ($stable(idx) && ovf));
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !idx_wr) |=> ovf);
  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(BUF_BYTES));
endmodule

// File: rtl/fsb_addr_reg.sv
module fsb_addr_reg #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_val,
  input  logic              done,
  input  logic [IDX_W-1:0]  step,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n)       addr <= '0;
    else if (done)    addr <= addr + ADDR_W'(step);
    else if (addr_wr) addr <= addr_val;
  end

  // R8
  post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (addr == $past(addr) + ADDR_W'($past(step))));
endmodule

// File: rtl/fsb_byte_store.sv
module fsb_byte_store #(
  parameter int BUF_BYTES = 32,
  parameter int BUS_BYTES = 4,
  localparam int IDX_W = $clog2(BUF_BYTES) + 1,
  localparam int POS_W = $clog2(BUF_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   store_en,
  input  logic [BUS_BYTES-1:0]   be,
  input  logic [8*BUS_BYTES-1:0] wdata,
  input  logic [IDX_W-1:0]       base,
  input  logic [POS_W-1:0]       eng_pos,
  output logic [7:0]             eng_byte
);
  logic [7:0]           mem [BUF_BYTES];
  logic [BUF_BYTES-1:0] vld;
  logic [IDX_W-1:0]     lane_pos [BUS_BYTES];
  logic [IDX_W-1:0]     run;

  // enabled lanes pack into consecutive positions
  always_comb begin
    run = base;
    for (int k = 0; k < BUS_BYTES; k++) begin
      lane_pos[k] = run;
      run = run + IDX_W'(be[k]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (clear) vld <= '0;
    else if (store_en) begin
      for (int k = 0; k < BUS_BYTES; k++)
        if (be[k]) vld[lane_pos[k][POS_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (store_en && !clear) begin
      for (int k = 0; k < BUS_BYTES; k++)
        if (be[k]) mem[lane_pos[k][POS_W-1:0]] <= wdata[8*k +: 8];
    end
  end

  assign eng_byte = vld[eng_pos] ? mem[eng_pos] : 8'hFF;

  // R2
  clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (vld == '0));
endmodule

// File: rtl/flash_stage_buf.sv
module flash_stage_buf #(
  parameter int BUF_BYTES = 32,
  parameter int BUS_BYTES = 4,
  parameter int ADDR_W    = 32,
  localparam int IDX_W = $clog2(BUF_BYTES) + 1,
  localparam int POS_W = $clog2(BUF_BYTES),
  localparam int DW    = 8 * BUS_BYTES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [7:0]           bus_ofs,
  input  logic [DW-1:0]        bus_wdata,
  input  logic [BUS_BYTES-1:0] bus_be,
  output logic [DW-1:0]        bus_rdata,
  input  logic                 prog_done,
  input  logic [POS_W-1:0]     eng_pos,
  output logic [7:0]           eng_byte,
  output logic [IDX_W-1:0]     fill_level,
  output logic [ADDR_W-1:0]    prog_addr,
  output logic                 overflow
);
  import fsb_pkg::*;

  logic wr_addr, wr_data, wr_idx;
  logic accept_evt, drop_evt;

  assign wr_addr = bus_wr && (bus_ofs == OFS_ADDR);
  assign wr_data = bus_wr && (bus_ofs == OFS_DATA);
  assign wr_idx  = bus_wr && (bus_ofs == OFS_INDEX);

  fsb_index_ctrl #(.BUF_BYTES(BUF_BYTES), .BUS_BYTES(BUS_BYTES)) u_idx (
    .clk(clk), .rst_n(rst_n), .idx_wr(wr_idx), .idx_raw(bus_wdata[IDX_W-1:0]),
    .dat_wr(wr_data), .be(bus_be), .addr_lo(prog_addr[POS_W-1:0]),
    .idx(fill_level), .ovf(overflow), .accept_evt(accept_evt), .drop_evt(drop_evt)
  );

  fsb_addr_reg #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_wr(wr_addr), .addr_val(ADDR_W'(bus_wdata)),
    .done(prog_done), .step(fill_level), .addr(prog_addr)
  );

  fsb_byte_store #(.BUF_BYTES(BUF_BYTES), .BUS_BYTES(BUS_BYTES)) u_store (
    .clk(clk), .rst_n(rst_n), .clear(wr_idx), .store_en(accept_evt),
    .be(bus_be), .wdata(bus_wdata), .base(fill_level),
    .eng_pos(eng_pos), .eng_byte(eng_byte)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_ofs == OFS_ADDR)       bus_rdata = DW'(prog_addr);
    else if (bus_ofs == OFS_INDEX) bus_rdata = DW'(fill_level);
  end

  // R5
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept_evt && drop_evt));
endmodule

// File: tb/test_flash_stage_buf.sv
module test_flash_stage_buf;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_ofs = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;
  logic        prog_done = 1'b0;
  logic [4:0]  eng_pos = '0;
  logic [7:0]  eng_byte;
  logic [5:0]  fill_level;
  logic [31:0] prog_addr;
  logic        overflow;

  int total = 0;
  int bad = 0;

  logic [7:0]  exp_mem [32];
  logic [31:0] exp_vld;
  int          exp_idx;
  logic [31:0] exp_addr;
  logic        exp_ovf;
  int          pat;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_stage_buf i_flash_stage_buf (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_ofs(bus_ofs),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
    .prog_done(prog_done), .eng_pos(eng_pos), .eng_byte(eng_byte),
    .fill_level(fill_level), .prog_addr(prog_addr), .overflow(overflow)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " index"}, 32'(fill_level), 32'(exp_idx));
    chk({tag, " address"}, prog_addr, exp_addr);
    chk({tag, " overflow"}, 32'(overflow), 32'(exp_ovf));
    for (int p = 0; p < 32; p++) begin
      eng_pos = 5'(p);
      #1;
      chk({tag, " R9 byte"}, 32'(eng_byte), exp_vld[p] ? 32'(exp_mem[p]) : 32'hFF);
    end
  endtask

  task automatic bus_write(input logic [7:0] ofs, input logic [31:0] d, input logic [3:0] be);
    int n, room, q;
    @(negedge clk);
    bus_wr = 1'b1; bus_ofs = ofs; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
    if (ofs == 8'h20) exp_addr = d;
    else if (ofs == 8'h28) begin
      exp_idx = (d[5:0] > 32) ? 32 : int'(d[5:0]);
      exp_vld = '0; exp_ovf = 1'b0;
    end else if (ofs == 8'h24) begin
      n = 0;
      for (int k = 0; k < 4; k++) if (be[k]) n++;
      room = 32 - int'(exp_addr % 32);
      if (n == 0) begin end
      else if (exp_idx + n <= room) begin
        q = exp_idx;
        for (int k = 0; k < 4; k++) if (be[k]) begin
          exp_mem[q] = d[8*k +: 8]; exp_vld[q] = 1'b1; q++;
        end
        exp_idx = q;
      end else exp_ovf = 1'b1;
    end
  endtask

  task automatic done_pulse(input bit with_addr_wr, input logic [31:0] d);
    @(negedge clk);
    prog_done = 1'b1;
    if (with_addr_wr) begin bus_wr = 1'b1; bus_ofs = 8'h20; bus_wdata = d; bus_be = 4'hF; end
    @(negedge clk);
    prog_done = 1'b0; bus_wr = 1'b0;
    exp_addr = exp_addr + 32'(exp_idx);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    exp_vld = '0; exp_idx = 0; exp_addr = '0; exp_ovf = 1'b0; pat = 1;
    for (int p = 0; p < 32; p++) exp_mem[p] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R3 lane packing for every enable mask, R4 for the empty mask
    for (int m = 0; m < 16; m++) begin
      bus_write(8'h20, 32'h0, 4'h0);
      bus_write(8'h28, 32'd3, 4'h0);
      bus_write(8'h24, 32'hA1B2C3D4 ^ 32'(m * 32'h01010101), 4'(m));
      check_all(m == 0 ? "R4 empty mask" : "R3 packing");
    end

    // R5 R6 R8 sweep over every start offset in the window
    for (int a = 0; a < 32; a++) begin
      bus_write(8'h20, 32'h0004_0000 + 32'(a), 4'hF);
      bus_write(8'h28, 32'd0, 4'hF);
      for (int w = 0; w < 9; w++) begin
        bus_write(8'h24, 32'(pat) * 32'h9E3779B1, 4'hF); pat++;
      end
      for (int b = 0; b < 5; b++) begin
        bus_write(8'h24, 32'(pat) * 32'h85EBCA6B, 4'h1); pat++;
      end
      check_all("R5 window edge");
      chk("R5 fill equals room", 32'(fill_level), 32'(32 - a));
      bus_write(8'h24, 32'h0, 4'h0);
      check_all("R6 sticky");
      done_pulse(1'b0, 32'h0);
      check_all("R8 advance");
      bus_write(8'h28, 32'd0, 4'hF);
      check_all("R2 clear");
    end

    // R2 saturation and index start offset
    bus_write(8'h20, 32'h0, 4'h0);
    bus_write(8'h28, 32'd45, 4'h0);
    check_all("R2 saturate");
    bus_write(8'h24, 32'h11223344, 4'h1);
    check_all("R5 full drop");
    bus_write(8'h28, 32'd7, 4'h0);
    bus_write(8'h24, 32'h55667788, 4'hF);
    bus_write(8'h24, 32'h99AABBCC, 4'h6);
    check_all("R3 offset start");

    // R7 address load ignores enables, R10 readback
    bus_write(8'h20, 32'hDEAD_BEE0, 4'h0);
    check_all("R7 load");
    bus_ofs = 8'h20; #1; chk("R10 addr read", bus_rdata, 32'hDEAD_BEE0);
    bus_ofs = 8'h28; #1; chk("R10 index read", bus_rdata, 32'(exp_idx));
    bus_ofs = 8'h24; #1; chk("R10 other read", bus_rdata, 32'h0);

    // R8 done beats an address write in the same cycle
    done_pulse(1'b1, 32'h1234_5678);
    check_all("R8 priority");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule